// File: doc/BRIEF.md
# Push-Button Voice Message Controller

This block is the control core of a key-operated voice recorder. A sample memory of `2**ADDR_W` words is split into one, two or four equal message slots. The split is taken from two select inputs when reset is released. Active-low message keys open record or playback sessions in the slot that belongs to each key. An active-low mode switch chooses between recording and playback. The controller drives a synchronous memory port (address, write strobe, read strobe), one sample per `smp_tick` pulse. It also raises a one-cycle beep request for an external tone generator and drives an active-low busy output.

Every key passes a debounce filter counted in pulses of a millisecond tick `ms_tick`. After reset the controller waits a programmable initialisation time, announces readiness with a beep, and only then accepts keys. A record session lasts as long as its key stays held, and each of its ends is marked by a beep. A playback session starts on a key press and stops on a second press of the same key or at the end of the stored message. One end-address register per slot remembers how far the last recording reached.

Top module: `voice_slot_ctrl`

## Requirements
- R1: When reset is released, the slot count is taken from `key_n[3:2]`: `2'b11` gives 4 slots, `2'b01` or `2'b10` gives 2 slots, `2'b00` gives 1 slot. Slot k spans addresses k*S to k*S+S-1, where S = 2**ADDR_W / slots.
- R2: `busy_n` is high while reset is asserted, during initialisation and while idle. It is low from the start beep of a record session until its end beep, and for the whole of a playback session.
- R3: After reset is released, keys are ignored for INIT_MS pulses of `ms_tick`. A single `beep` pulse follows, and only then is a new key press accepted. A key already held through initialisation starts nothing.
- R4: A key change counts only after the new level has persisted for DEB_MS consecutive `ms_tick` pulses. A shorter press, or a shorter release during recording, has no effect.
- R5: In record mode (`rec_n` low), a press raises one `beep` pulse. Each later `smp_tick` then writes one sample (`mem_we`), from the slot's first address upward.
- R6: Releasing the key ends recording with one `beep` pulse. The number of samples written becomes the stored message length.
- R7: Once the slot's last address has been written, recording stops with one `beep` pulse even if the key is still held. No write leaves the slot.
- R8: Recording into a slot that holds a message replaces it, and the new length, shorter or longer, is what playback uses.
- R9: In playback mode (`rec_n` high), a press starts reading (`mem_re`) from the slot's first address, one read per `smp_tick`. The session ends after the last stored sample.
- R10: A second debounced press of the same key during playback stops it at once. Later `smp_tick` pulses cause no reads.
- R11: Playing a slot that is empty (never recorded since the slot count was latched, or recorded with zero samples) returns to idle without any read.
- R12: With 2 slots only keys 0 and 1 are active, and with 1 slot only key 0 is. Presses of other keys start no session.
- R13: `mem_we` and `mem_re` are never high together, and `beep` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle pulse every millisecond, used for debounce and initialisation timing |
| smp_tick | input | 1 | One-cycle pulse per audio sample |
| rec_n | input | 1 | Mode switch, low selects record and high selects playback |
| key_n | input | 4 | Active-low message keys; bits 3:2 also act as slot-count selects at reset release |
| mem_addr | output | ADDR_W | Sample memory address |
| mem_we | output | 1 | Sample write strobe |
| mem_re | output | 1 | Sample read strobe |
| beep | output | 1 | One-cycle request for an indication tone |
| busy_n | output | 1 | Low while a record or playback session runs |

## Verification
The bench goes after slot edges. It fills a slot exactly to its last address and beyond it, which a design with an off-by-one end check would overrun into the next slot or stop one sample short. It re-records a slot with a shorter message: a design that kept the old length would replay stale samples. It plays an untouched slot, where a design that treats empty as full would issue reads. It sends key glitches shorter than the debounce window, both as presses and as releases mid-recording; a filter that is too weak would start sessions or cut recordings short. Restarts with other select settings show whether the slot size and the set of active keys follow the latched count, and whether stored lengths from the previous layout are dropped.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  localparam int NKEY = 4;
  localparam int KW   = 2;

  typedef enum logic [2:0] {
    ST_LATCH,
    ST_INIT,
    ST_HELLO,
    ST_IDLE,
    ST_RBEEP,
    ST_REC,
    ST_RDONE,
    ST_PLAY
  } vsc_state_e;

  // log2 of the slot count from the two select levels
  function automatic logic [1:0] slot_lg(input logic [1:0] sel);
    case (sel)
      2'b11:   slot_lg = 2'd2;
      2'b00:   slot_lg = 2'd0;
      default: slot_lg = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/vsc_debounce.sv
module vsc_debounce #(
  parameter int DEB_MS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic raw_n,
  output logic held_o,
  output logic press_o
);

  localparam int CW = $clog2(DEB_MS + 1);

  logic          s1_q, s2_q;
  logic          stable_q, stable_d;
  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    stable_d = stable_q;
    cnt_d    = cnt_q;
    if (s2_q == stable_q) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      if (cnt_q == CW'(DEB_MS - 1)) begin
        stable_d = s2_q;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b1;
      s2_q     <= 1'b1;
      stable_q <= 1'b1;
      prev_q   <= 1'b1;
      cnt_q    <= '0;
    end else begin
      s1_q     <= raw_n;
      s2_q     <= s1_q;
      stable_q <= stable_d;
      prev_q   <= stable_q;
      cnt_q    <= cnt_d;
    end
  end

  assign held_o  = ~stable_q;
  assign press_o = prev_q & ~stable_q;

  // R4: the filtered level only moves on a millisecond tick
  p_filter_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_q != $past(stable_q)) |-> $past(ms_tick));

  // R4: a press pulse is never followed by another without a release between
  p_press_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o);

endmodule

// File: rtl/vsc_slot_map.sv
module vsc_slot_map #(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]      lg,
  input  logic [1:0]      idx,
  output logic [ADDR_W:0] start_o,
  output logic [ADDR_W:0] last_o,
  output logic            active_o
);

  localparam int PW = ADDR_W + 1;

  logic [ADDR_W:0] size;
  int              sh;

  always_comb begin
    sh       = ADDR_W - int'(lg);
    size     = PW'(1) << sh;
    start_o  = PW'(idx) << sh;
    last_o   = start_o + size - PW'(1);
    active_o = int'(idx) < (1 << lg);
  end

endmodule

// File: rtl/vsc_end_store.sv
module vsc_end_store #(
  parameter int ADDR_W = 8,
  parameter int NSLOT  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [1:0]      lg,
  input  logic            wr_en,
  input  logic [1:0]      wr_idx,
  input  logic [ADDR_W:0] wr_end,
  input  logic [1:0]      rd_idx,
  output logic [ADDR_W:0] rd_end
);

  logic [ADDR_W:0] end_q [NSLOT];
  logic [ADDR_W:0] st    [NSLOT];
  logic [ADDR_W:0] la    [NSLOT];
  logic            act   [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    vsc_slot_map #(.ADDR_W(ADDR_W)) i_map (
      .lg      (lg),
      .idx     (2'(g)),
      .start_o (st[g]),
      .last_o  (la[g]),
      .active_o(act[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        end_q[g] <= '0;
      end else if (clr) begin
        end_q[g] <= st[g];
      end else if (wr_en && (wr_idx == 2'(g))) begin
        end_q[g] <= wr_end;
      end
    end

    // R6 R7: a stored end stays inside its own active slot
    p_end_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && (wr_idx == 2'(g))) |->
        (act[g] && (wr_end >= st[g]) && (wr_end <= la[g] + 1'b1)));
  end

  assign rd_end = end_q[rd_idx];

endmodule

// File: rtl/voice_slot_ctrl.sv
module voice_slot_ctrl
  import vsc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INIT_MS = 100,
  parameter int DEB_MS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              smp_tick,
  input  logic              rec_n,
  input  logic [NKEY-1:0]   key_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic              beep,
  output logic              busy_n
);

  localparam int IW = $clog2(INIT_MS + 1);
  localparam int PW = ADDR_W + 1;

  // reset release and mode switch synchronisers
  logic rs1_q, rst_s;
  logic md1_q, md2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      md1_q <= 1'b1;
      md2_q <= 1'b1;
    end else begin
      md1_q <= rec_n;
      md2_q <= md1_q;
    end
  end

  // key conditioning
  logic [NKEY-1:0] held, press;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    vsc_debounce #(.DEB_MS(DEB_MS)) i_deb (
      .clk    (clk),
      .rst_n  (rst_s),
      .ms_tick(ms_tick),
      .raw_n  (key_n[g]),
      .held_o (held[g]),
      .press_o(press[g])
    );
  end

  // state
  vsc_state_e      state_q, state_d;
  logic [1:0]      lg_q, lg_d;
  logic [KW-1:0]   cur_q, cur_d;
  logic [ADDR_W:0] ptr_q, ptr_d;
  logic [IW-1:0]   icnt_q, icnt_d;

  // lowest-numbered active key with a fresh press
  logic          found;
  logic [KW-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = NKEY - 1; k >= 0; k--) begin
      if (press[k] && (k < (1 << lg_q))) begin
        found = 1'b1;
        pick  = KW'(k);
      end
    end
  end

  // slot geometry of the key being served (or about to be)
  logic [KW-1:0]   map_idx;
  logic [ADDR_W:0] map_start, map_last;
  logic            map_act;

  assign map_idx = (state_q == ST_IDLE) ? pick : cur_q;

  vsc_slot_map #(.ADDR_W(ADDR_W)) i_map (
    .lg      (lg_q),
    .idx     (map_idx),
    .start_o (map_start),
    .last_o  (map_last),
    .active_o(map_act)
  );

  // per-slot end addresses
  logic            end_clr, end_we;
  logic [ADDR_W:0] end_val, rd_end;

  vsc_end_store #(.ADDR_W(ADDR_W), .NSLOT(NKEY)) i_ends (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (end_clr),
    .lg    (lg_q),
    .wr_en (end_we),
    .wr_idx(cur_q),
    .wr_end(end_val),
    .rd_idx(cur_q),
    .rd_end(rd_end)
  );

  // next state
  always_comb begin
    state_d = state_q;
    lg_d    = lg_q;
    cur_d   = cur_q;
    ptr_d   = ptr_q;
    icnt_d  = icnt_q;
    end_clr = 1'b0;
    end_we  = 1'b0;
    end_val = ptr_q;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    beep    = 1'b0;
    case (state_q)
      ST_LATCH: begin
        lg_d    = slot_lg(key_n[3:2]);
        icnt_d  = '0;
        state_d = ST_INIT;
      end
      ST_INIT: begin
        end_clr = 1'b1;
        if (ms_tick) begin
          if (icnt_q == IW'(INIT_MS - 1)) begin
            state_d = ST_HELLO;
          end else begin
            icnt_d = icnt_q + 1'b1;
          end
        end
      end
      ST_HELLO: begin
        beep    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (found) begin
          cur_d = pick;
          if (!md2_q) begin
            state_d = ST_RBEEP;
          end else begin
            ptr_d   = map_start;
            state_d = ST_PLAY;
          end
        end
      end
      ST_RBEEP: begin
        beep    = 1'b1;
        ptr_d   = map_start;
        state_d = ST_REC;
      end
      ST_REC: begin
        if (!held[cur_q]) begin
          end_we  = 1'b1;
          end_val = ptr_q;
          state_d = ST_RDONE;
        end else if (smp_tick) begin
          mem_we = 1'b1;
          if (ptr_q == map_last) begin
            end_we  = 1'b1;
            end_val = ptr_q + 1'b1;
            state_d = ST_RDONE;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      ST_RDONE: begin
        beep    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_PLAY: begin
        if (press[cur_q]) begin
          state_d = ST_IDLE;
        end else if (ptr_q == rd_end) begin
          state_d = ST_IDLE;
        end else if (smp_tick) begin
          mem_re = 1'b1;
          ptr_d  = ptr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_LATCH;
      lg_q    <= 2'd2;
      cur_q   <= '0;
      ptr_q   <= '0;
      icnt_q  <= '0;
    end else begin
      state_q <= state_d;
      lg_q    <= lg_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
      icnt_q  <= icnt_d;
    end
  end

  assign mem_addr = ptr_q[ADDR_W-1:0];
  assign busy_n   = !((state_q == ST_RBEEP) || (state_q == ST_REC) ||
                      (state_q == ST_RDONE) || (state_q == ST_PLAY));

  // R13: never read and write in the same cycle
  p_no_rw_overlap_r13: assert property (@(posedge clk) disable iff (!rst_s)
    !(mem_we && mem_re));

  // R13: beep requests are single-cycle
  p_beep_single_r13: assert property (@(posedge clk) disable iff (!rst_s)
    beep |=> !beep);

  // R2: memory traffic only inside a session
  p_access_busy_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_we || mem_re) |-> !busy_n);

  // R3: a session can only open from the idle state
  p_open_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy_n) |-> ($past(state_q) == ST_IDLE));

  // R5 R7: writes stay within the slot being recorded
  p_write_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> ((ptr_q >= map_start) && (ptr_q <= map_last)));

  // R9: reads never pass the stored end
  p_read_before_end_r9: assert property (@(posedge clk) disable iff (!rst_s)
    mem_re |-> (ptr_q < rd_end));

  // R12: a running session always belongs to an active key
  p_session_key_active_r12: assert property (@(posedge clk) disable iff (!rst_s)
    !busy_n |-> map_act);

endmodule

// File: tb/test_voice_slot_ctrl.sv
`timescale 1ns/1ps
module test_voice_slot_ctrl;

  localparam int AW    = 6;
  localparam int INITM = 5;
  localparam int DEBM  = 3;
  localparam int SLOT4 = 16;
  localparam int NT    = 9;

  // {record, key, sample ticks, expected strobes}
  localparam logic [31:0] TBL [NT] = '{
    {8'd1, 8'd0, 8'd10, 8'd10},  // R5 R6: record key0, release after 10
    {8'd1, 8'd1, 8'd20, 8'd16},  // R7: overfill slot1, stops at 16
    {8'd1, 8'd3, 8'd16, 8'd16},  // R7: exactly fill last slot
    {8'd0, 8'd0, 8'd12, 8'd10},  // R9: play back 10
    {8'd0, 8'd1, 8'd20, 8'd16},  // R9: full slot playback
    {8'd1, 8'd0, 8'd4,  8'd4},   // R8: shorter re-record
    {8'd0, 8'd0, 8'd12, 8'd4},   // R8: new length used
    {8'd0, 8'd2, 8'd5,  8'd0},   // R11: empty slot, no reads
    {8'd0, 8'd3, 8'd20, 8'd16}   // R9: top slot up to address 63
  };

  logic          clk;
  logic          rst_n;
  logic          ms_tick;
  logic          smp_tick;
  logic          rec_n;
  logic [3:0]    key_n;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, beep, busy_n;

  voice_slot_ctrl #(.ADDR_W(AW), .INIT_MS(INITM), .DEB_MS(DEBM)) i_voice_slot_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .smp_tick(smp_tick),
    .rec_n   (rec_n),
    .key_n   (key_n),
    .mem_addr(mem_addr),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .beep    (beep),
    .busy_n  (busy_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_rd = 0;
  int n_beep = 0;
  int cyc = 0;
  int wr_log [1024];
  int rd_log [1024];
  logic [1:0] msdiv = 2'd0;

  // millisecond tick: one cycle in four
  always @(negedge clk) begin
    msdiv   <= msdiv + 2'd1;
    ms_tick <= (msdiv == 2'd3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_we) begin
        wr_log[n_wr % 1024] = int'(mem_addr);
        n_wr = n_wr + 1;
      end
      if (mem_re) begin
        rd_log[n_rd % 1024] = int'(mem_addr);
        n_rd = n_rd + 1;
      end
      if (beep) n_beep = n_beep + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_smp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) smp_tick = 1'b1;
      @(negedge clk) smp_tick = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic [3:0] after);
    @(negedge clk);
    rst_n = 1'b0;
    key_n = {sel, 2'b11};
    wait_cyc(5);
    check("R2 busy_n in reset", int'(busy_n), 1);
    check("R13 no strobes in reset", int'(mem_we | mem_re | beep), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    key_n = after;
  endtask

  task automatic session(input logic rec, input int k, input int nt);
    rec_n = ~rec;
    wait_cyc(3);
    key_n[k] = 1'b0;
    wait_cyc(30);
    pulse_smp(nt);
    key_n[k] = 1'b1;
    wait_cyc(30);
  endtask

  int w0, r0, b0, cnt;
  logic rec;
  int k, nt, ex;

  initial begin
    rst_n = 1'b0; key_n = 4'hF; rec_n = 1'b0; smp_tick = 1'b0; ms_tick = 1'b0;

    // R3: key0 held from reset release in record mode, 4 slots
    do_reset(2'b11, 4'b1110);
    b0 = n_beep;
    check("R3 no beep during init", n_beep, 0);
    wait_cyc(40);
    check("R3 one ready beep", n_beep - b0, 1);
    check("R3 held key ignored", int'(busy_n), 1);
    check("R3 no writes", n_wr, 0);
    key_n[0] = 1'b1;
    wait_cyc(30);
    check("R3 release idle", int'(busy_n), 1);

    // R4: press glitch shorter than the filter
    b0 = n_beep;
    key_n[0] = 1'b0; wait_cyc(6); key_n[0] = 1'b1;
    wait_cyc(30);
    check("R4 short press ignored busy_n", int'(busy_n), 1);
    check("R4 short press no beep", n_beep - b0, 0);

    // table walk
    for (int i = 0; i < NT; i++) begin
      rec = TBL[i][24];
      k   = int'(TBL[i][23:16]);
      nt  = int'(TBL[i][15:8]);
      ex  = int'(TBL[i][7:0]);
      w0 = n_wr; r0 = n_rd; b0 = n_beep;
      session(rec, k, nt);
      cnt = rec ? n_wr - w0 : n_rd - r0;
      check(rec ? "R5 write count" : "R9 read count", cnt, ex);
      check(rec ? "R6 beeps" : "R9 no beeps", n_beep - b0, rec ? 2 : 0);
      check("R2 idle after session", int'(busy_n), 1);
      check(rec ? "R9 no reads in record" : "R13 no writes in play",
            rec ? n_rd - r0 : n_wr - w0, 0);
      if (ex > 0) begin
        check("R1 first address", rec ? wr_log[w0 % 1024] : rd_log[r0 % 1024], k * SLOT4);
        check("R7 last address", rec ? wr_log[(w0 + ex - 1) % 1024] : rd_log[(r0 + ex - 1) % 1024],
              k * SLOT4 + ex - 1);
      end
    end

    // R4: short release during recording keeps it going
    w0 = n_wr;
    rec_n = 1'b0; wait_cyc(3);
    key_n[2] = 1'b0; wait_cyc(30);
    check("R2 busy_n low while recording", int'(busy_n), 0);
    pulse_smp(3);
    key_n[2] = 1'b1; wait_cyc(6); key_n[2] = 1'b0;
    pulse_smp(3);
    key_n[2] = 1'b1; wait_cyc(30);
    check("R4 short release ignored", n_wr - w0, 6);

    // R10: second press stops playback
    r0 = n_rd;
    rec_n = 1'b1; wait_cyc(3);
    key_n[3] = 1'b0; wait_cyc(30);
    check("R2 busy_n low while playing", int'(busy_n), 0);
    pulse_smp(4);
    key_n[3] = 1'b1; wait_cyc(30);
    key_n[3] = 1'b0; wait_cyc(30);
    check("R10 stopped busy_n", int'(busy_n), 1);
    pulse_smp(4);
    check("R10 reads before stop only", n_rd - r0, 4);
    key_n[3] = 1'b1; wait_cyc(30);

    // R1 R12: two-slot layout (key_n[2] low at release)
    do_reset(2'b10, 4'hF);
    wait_cyc(40);
    w0 = n_wr;
    session(1'b1, 1, 40);
    check("R1 two-slot length", n_wr - w0, 32);
    check("R1 two-slot start", wr_log[w0 % 1024], 32);
    check("R1 two-slot end", wr_log[(w0 + 31) % 1024], 63);
    r0 = n_rd;
    session(1'b0, 0, 5);
    check("R11 old layout discarded", n_rd - r0, 0);
    w0 = n_wr;
    rec_n = 1'b0; wait_cyc(3);
    key_n[2] = 1'b0; wait_cyc(30);
    check("R12 key2 inactive busy_n", int'(busy_n), 1);
    pulse_smp(3);
    key_n[2] = 1'b1; wait_cyc(30);
    check("R12 key2 no writes", n_wr - w0, 0);

    // R1 R12: one-slot layout
    do_reset(2'b00, 4'hF);
    wait_cyc(40);
    w0 = n_wr;
    session(1'b1, 0, 70);
    check("R1 one-slot length", n_wr - w0, 64);
    check("R1 one-slot end", wr_log[(w0 + 63) % 1024], 63);
    w0 = n_wr;
    session(1'b1, 1, 3);
    check("R12 key1 inactive", n_wr - w0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule